// File: doc/BRIEF.md
# LIN Header Break and Sync Detector

This block watches the serial receive line of a UART running in LIN mode and recognizes the header that starts every LIN frame. First it finds the break, which is a dominant low lasting well past one character. It then counts the falling edges of the 0x55 sync byte and checks the two parity bits of the protected identifier byte. All timing is taken from a 16x oversampling baud tick, so the thresholds are counts of ticks rather than of clocks.

Detecting sync does two things. It raises a sticky sync flag. It also emits a one-cycle pulse that resets the receive FIFO address pointers, so that the next byte, the identifier, is stored at the front of the FIFO. The number of ticks between the first and last counted edges of the sync byte is published for baud-rate measurement.

Byte deserialization and the FIFO itself belong to the neighbouring receiver. That receiver hands this block each received identifier byte with a valid strobe. Software clears the flags by reading the status register that holds them, and that read reaches this block as a strobe.

Top module: `lin_hdr_detect`

## Requirements
- R1: The break flag sets when the synchronized line has been sampled low on BREAK_TICKS (default 184, 11.5 bit times) consecutive oversample ticks. A run of 183 low ticks does not set it, and a single high sample restarts the count.
- R2: After a break and the line's return high, the fifth falling edge (SYNC_EDGES) sets the sync flag. Falling edges that do not follow a break have no effect.
- R3: When sync is detected, fifo_ptr_rst_o is high for exactly one clock cycle. sync_ticks_o takes its new value in that same cycle.
- R4: On pid_vld_i the parity-error flag sets if bit 6 differs from ID0^ID1^ID2^ID4 or bit 7 differs from ~(ID1^ID3^ID4^ID5), where ID0..ID5 are bits 0..5 of pid_i. A correct byte leaves the flag unchanged.
- R5: A stat_rd_i strobe clears the break, sync and parity-error flags on the next clock edge. A flag being set in that same cycle wins over the clear.
- R6: While counting edges, if more than GAP_BITS*OSR ticks (default 32) pass with no falling edge, the detector drops back to idle. It ignores further edges until the next break.
- R7: sync_ticks_o holds the number of oversample ticks from the first falling edge to the fifth. This is 8 bit times: 128 at 16 ticks per bit, 112 at 14.
- R8: After reset all three flags, fifo_ptr_rst_o and sync_ticks_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Raw asynchronous receive line, idle high |
| os_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| pid_i | input | 8 | Received identifier byte |
| pid_vld_i | input | 1 | pid_i is valid this cycle |
| stat_rd_i | input | 1 | Status register read strobe, clears flags |
| brk_flag_o | output | 1 | Break seen, sticky until read |
| sync_flag_o | output | 1 | Sync seen, sticky until read |
| pid_err_o | output | 1 | Identifier parity mismatch, sticky until read |
| fifo_ptr_rst_o | output | 1 | One-cycle pulse resetting the receive FIFO pointers |
| sync_ticks_o | output | TICKS_W (8) | Ticks between the first and fifth sync falling edges |

## Verification
The break counter is tried with several low runs:
- a run one tick short of the threshold, which tells "at least" apart from "more than";
- a run split by one high sample, which shows that the count restarts;
- a full-length run, which must set the flag.

Complete headers are sent at 16 and at 14 ticks per bit, so that the published interval is shown to scale with the real bit rate rather than being a constant. Sync bytes are also sent with no break before them, after a delimiter that is too long, and with edges spaced too widely. These separate the break arming from the gap timeout. The identifier checker receives good bytes, bytes with P0 alone wrong and bytes with P1 alone wrong, which shows that each parity equation is checked on its own.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  typedef enum logic [1:0] {
    SY_IDLE  = 2'd0,
    SY_ARMED = 2'd1,
    SY_COUNT = 2'd2
  } sync_st_e;

  // {P1, P0} expected for a 6-bit identifier
  function automatic logic [1:0] pid_parity(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0};
  endfunction

endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd_i,
  output logic lvl_o,
  output logic fall_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= rxd_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign lvl_o  = chain[STAGES-1];
  assign fall_o = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/lin_break_det.sv
module lin_break_det #(
  parameter int BREAK_TICKS = 184
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic lvl_i,
  output logic brk_hit_o
);
  localparam int BW = $clog2(BREAK_TICKS + 1);

  logic [BW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      brk_hit_o <= 1'b0;
    end else begin
      brk_hit_o <= 1'b0;
      if (tick_i) begin
        if (lvl_i) begin
          low_cnt <= '0;
        end else if (low_cnt < BW'(BREAK_TICKS)) begin
          low_cnt <= low_cnt + 1'b1;
          if (low_cnt == BW'(BREAK_TICKS - 1)) brk_hit_o <= 1'b1;
        end
      end
    end
  end

  AST_BRK_ON_LOW_TICK: assert property (@(posedge clk) disable iff (rst)
    brk_hit_o |-> ($past(tick_i) && !$past(lvl_i))); // R1

  AST_BRK_ONE_PER_RUN: assert property (@(posedge clk) disable iff (rst)
    brk_hit_o |=> !brk_hit_o); // R1

endmodule

// File: rtl/lin_sync_ctr.sv
module lin_sync_ctr
  import lin_hdr_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int SYNC_EDGES = 5,
  parameter int GAP_BITS   = 2,
  parameter int TICKS_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               lvl_i,
  input  logic               fall_i,
  input  logic               brk_hit_i,
  output logic               sync_hit_o,
  output logic [TICKS_W-1:0] ticks_o
);
  localparam int GAP = GAP_BITS * OSR;
  localparam int EW  = $clog2(SYNC_EDGES + 1);
  localparam int GW  = $clog2(GAP + 2);

  sync_st_e           st;
  logic [EW-1:0]      ecnt;
  logic [GW-1:0]      gap_tmr;
  logic [TICKS_W-1:0] span;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SY_IDLE;
      ecnt       <= '0;
      gap_tmr    <= '0;
      span       <= '0;
      ticks_o    <= '0;
      sync_hit_o <= 1'b0;
    end else begin
      sync_hit_o <= 1'b0;
      if (brk_hit_i) begin
        st <= SY_ARMED;
      end else begin
        case (st)
          SY_ARMED: begin
            if (lvl_i) begin
              st      <= SY_COUNT;
              gap_tmr <= '0;
              ecnt    <= '0;
            end
          end
          SY_COUNT: begin
            if (fall_i) begin
              gap_tmr <= '0;
              ecnt    <= ecnt + 1'b1;
              if (ecnt == '0) span <= '0;
              else            span <= span + TICKS_W'(tick_i);
              if (ecnt == EW'(SYNC_EDGES - 1)) begin
                sync_hit_o <= 1'b1;
                ticks_o    <= span + TICKS_W'(tick_i);
                st         <= SY_IDLE;
              end
            end else if (tick_i) begin
              if (gap_tmr == GW'(GAP)) st <= SY_IDLE;
              else                     gap_tmr <= gap_tmr + 1'b1;
              if (ecnt != '0) span <= span + 1'b1;
            end
          end
          default: st <= SY_IDLE;
        endcase
      end
    end
  end

  AST_SYNC_FROM_COUNT: assert property (@(posedge clk) disable iff (rst)
    sync_hit_o |-> ($past(st) == SY_COUNT && $past(fall_i))); // R2

  AST_IDLE_IGNORES_EDGE: assert property (@(posedge clk) disable iff (rst)
    (st == SY_IDLE && !brk_hit_i) |=> (st == SY_IDLE && !sync_hit_o)); // R6

  AST_TICKS_HELD: assert property (@(posedge clk) disable iff (rst)
    !sync_hit_o |-> $stable(ticks_o)); // R7

endmodule

// File: rtl/lin_pid_chk.sv
module lin_pid_chk
  import lin_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] pid_i,
  input  logic       pid_vld_i,
  input  logic       clr_i,
  output logic       err_o
);
  logic mismatch;

  always_comb mismatch = (pid_i[7:6] != pid_parity(pid_i[5:0]));

  always_ff @(posedge clk) begin
    if (rst)                        err_o <= 1'b0;
    else if (pid_vld_i && mismatch) err_o <= 1'b1;
    else if (clr_i)                 err_o <= 1'b0;
  end

  AST_PID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pid_vld_i && !clr_i) |=> $stable(err_o)); // R4

endmodule

// File: rtl/lin_hdr_detect.sv
module lin_hdr_detect
  import lin_hdr_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int BREAK_TICKS = 184,
  parameter int SYNC_EDGES  = 5,
  parameter int GAP_BITS    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int TICKS_W     = $clog2((SYNC_EDGES - 1) * GAP_BITS * OSR + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rxd_i,
  input  logic               os_tick_i,
  input  logic [7:0]         pid_i,
  input  logic               pid_vld_i,
  input  logic               stat_rd_i,
  output logic               brk_flag_o,
  output logic               sync_flag_o,
  output logic               pid_err_o,
  output logic               fifo_ptr_rst_o,
  output logic [TICKS_W-1:0] sync_ticks_o
);
  logic lvl, fall, brk_hit, sync_hit;

  lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rxd_i(rxd_i), .lvl_o(lvl), .fall_o(fall)
  );

  lin_break_det #(.BREAK_TICKS(BREAK_TICKS)) u_brk (
    .clk(clk), .rst(rst), .tick_i(os_tick_i), .lvl_i(lvl), .brk_hit_o(brk_hit)
  );

  lin_sync_ctr #(
    .OSR(OSR), .SYNC_EDGES(SYNC_EDGES), .GAP_BITS(GAP_BITS), .TICKS_W(TICKS_W)
  ) u_edges (
    .clk(clk), .rst(rst), .tick_i(os_tick_i), .lvl_i(lvl), .fall_i(fall),
    .brk_hit_i(brk_hit), .sync_hit_o(sync_hit), .ticks_o(sync_ticks_o)
  );

  lin_pid_chk u_pid (
    .clk(clk), .rst(rst), .pid_i(pid_i), .pid_vld_i(pid_vld_i),
    .clr_i(stat_rd_i), .err_o(pid_err_o)
  );

  assign fifo_ptr_rst_o = sync_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_flag_o  <= 1'b0;
      sync_flag_o <= 1'b0;
    end else begin
      if (brk_hit)        brk_flag_o <= 1'b1;
      else if (stat_rd_i) brk_flag_o <= 1'b0;
      if (sync_hit)       sync_flag_o <= 1'b1;
      else if (stat_rd_i) sync_flag_o <= 1'b0;
    end
  end

  AST_FLAGS_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_i && !brk_hit && !sync_hit) |=> (!brk_flag_o && !sync_flag_o)); // R5

  AST_PTR_RST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    fifo_ptr_rst_o |=> !fifo_ptr_rst_o); // R3

  AST_SYNC_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    fifo_ptr_rst_o |=> sync_flag_o); // R2

endmodule

// File: tb/lin_hdr_detect_test.sv
module lin_hdr_detect_test;
  localparam int OSR = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       os_tick = 1'b0;
  logic [7:0] pid = 8'h00;
  logic       pid_vld = 1'b0;
  logic       stat_rd = 1'b0;
  logic       brk_flag, sync_flag, pid_err, ptr_rst;
  logic [7:0] ticks;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  int exp_q[$];
  bit prev_ptr = 1'b0;

  always #10 clk = ~clk;

  lin_hdr_detect uut (
    .clk(clk), .rst(rst), .rxd_i(rxd), .os_tick_i(os_tick),
    .pid_i(pid), .pid_vld_i(pid_vld), .stat_rd_i(stat_rd),
    .brk_flag_o(brk_flag), .sync_flag_o(sync_flag), .pid_err_o(pid_err),
    .fifo_ptr_rst_o(ptr_rst), .sync_ticks_o(ticks)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // hold the line at lvl for n tick periods of 4 clocks, tick on the last clock
  task automatic hold(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = lvl;
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  endtask

  // 0x55 framed: start, 8 data bits LSB first, stop
  task automatic send_sync_byte(input int bt);
    logic [9:0] frame;
    frame = {1'b1, 8'h55, 1'b0};
    for (int b = 0; b < 10; b++) hold(frame[b], bt);
    hold(1'b1, bt);
  endtask

  task automatic send_header(input int bt, input int delim, input bit expect_sync);
    if (expect_sync) exp_q.push_back(8 * bt);
    hold(1'b0, 200);
    hold(1'b1, delim);
    send_sync_byte(bt);
  endtask

  task automatic read_status();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] good_pid(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  task automatic send_pid(input logic [7:0] b);
    pid = b;
    pid_vld = 1'b1;
    @(negedge clk);
    pid_vld = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (ptr_rst) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected sync pulse", 1, 0);
        end else begin
          check("R7 sync_ticks", int'(ticks), exp_q.pop_front());
        end
        check("R3 pointer reset single cycle", int'(prev_ptr), 0);
      end
      prev_ptr = ptr_rst;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 brk_flag reset", brk_flag, 0);
    check("R8 sync_flag reset", sync_flag, 0);
    check("R8 pid_err reset", pid_err, 0);
    check("R8 ptr_rst reset", ptr_rst, 0);
    check("R8 sync_ticks reset", int'(ticks), 0);

    hold(1'b1, 20);
    hold(1'b0, 183);
    hold(1'b1, 20);
    check("R1 183 low ticks no break", brk_flag, 0);

    hold(1'b0, 100);
    hold(1'b1, 1);
    hold(1'b0, 100);
    hold(1'b1, 20);
    check("R1 high sample restarts count", brk_flag, 0);

    hold(1'b0, 184);
    hold(1'b1, 1);
    check("R1 184 low ticks break", brk_flag, 1);
    hold(1'b1, 40);
    read_status();
    check("R5 brk cleared by read", brk_flag, 0);

    send_header(16, 16, 1'b1);
    check("R1 header break flag", brk_flag, 1);
    check("R2 header sync flag", sync_flag, 1);
    read_status();
    check("R5 brk cleared", brk_flag, 0);
    check("R5 sync cleared", sync_flag, 0);

    send_header(14, 14, 1'b1);
    check("R2 sync flag at 14 ticks/bit", sync_flag, 1);
    read_status();

    hold(1'b1, 40);
    send_sync_byte(16);
    check("R2 no break no sync", sync_flag, 0);

    send_header(16, 40, 1'b0);
    check("R6 long delimiter break flag", brk_flag, 1);
    check("R6 long delimiter no sync", sync_flag, 0);
    read_status();

    send_header(17, 16, 1'b0);
    check("R6 wide edge gap no sync", sync_flag, 0);
    read_status();

    send_pid(good_pid(6'h3C));
    check("R4 good pid 0x3C", pid_err, 0);
    send_pid(good_pid(6'h00));
    check("R4 good pid 0x00", pid_err, 0);
    send_pid(good_pid(6'h15) ^ 8'h40);
    check("R4 P0 wrong", pid_err, 1);
    read_status();
    check("R5 pid_err cleared", pid_err, 0);
    send_pid(good_pid(6'h2A) ^ 8'h80);
    check("R4 P1 wrong", pid_err, 1);
    send_pid(good_pid(6'h2A));
    check("R4 good byte keeps sticky flag", pid_err, 1);
    read_status();
    check("R5 pid_err cleared again", pid_err, 0);

    hold(1'b1, 4);
    check("R7 all expected syncs seen", exp_q.size(), 0);
    finish_run();
  end
endmodule